// File: doc/BRIEF.md
# Mode-Dependent Segment Address Unit

This unit turns a segment-relative effective address into a linear address and reports segment-limit violations. It keeps a small register file with one base and one limit per segment. A request names a segment, gives an effective address, an access size in bytes, a read or write flag, the current privilege level and two mode bits. The unit picks the base, adds it to the address and compares the last byte touched against the segment limit. The result comes back one cycle later as a registered linear address with a fault flag beside it.

The two mode bits set the rules. With the wide-mode flag low (32-bit protected operation), every segment adds its base and checks its limit, using the low 32 bits of the address. With the wide-mode flag high, only the two auxiliary segments (codes 4 and 5) add their base. Limit checks apply only when the limit-enable flag is set, the privilege level is above 0, and the segment is one of the four data-like segments (codes 1 to 4).

Requests and results each use a valid/ready handshake. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. The result register holds its contents while `rsp_valid` is high and `rsp_ready` is low. `req_ready` is low only while a result is held this way, so back-pressure reaches the requester in the same cycle. The configuration port is a plain write strobe and has no handshake.

Top module: `seg_addr_unit`

## Requirements
- R1: After reset, `rsp_valid` is 0, `req_ready` is 1, every stored base is 0 and every stored limit is all ones.
- R2: A configuration write (`cfg_we`=1, index `cfg_idx`) stores `cfg_base` and `cfg_limit` on that clock edge, and any request accepted on a later edge uses the new values.
- R3: Segment codes are 0 code, 1 data, 2 extra, 3 stack, 4 aux-F, 5 aux-G. In wide mode, codes 0 to 3 ignore the stored base, so `rsp_lin` equals the 64-bit effective address.
- R4: In wide mode, codes 4 and 5 give `rsp_lin` = effective address + stored base, modulo 2^64.
- R5: In 32-bit mode, `rsp_lin` = (`req_ea[31:0]` + base[31:0]) modulo 2^32, zero-extended to 64 bits.
- R6: In 32-bit mode, every segment 0 to 5 faults when `req_ea[31:0]` + size − 1 exceeds the limit. The sum is taken without wrap, and a size of 0 counts as 1.
- R7: In wide mode, a limit check is applied only when `req_limchk_en`=1, `req_cpl`>0 and the segment is code 1, 2, 3 or 4. It faults when the full 64-bit address + size − 1, taken without wrap, exceeds the zero-extended limit. With any of these conditions false, there is no fault.
- R8: In wide mode, codes 0 and 5 never fault, even with `req_limchk_en`=1 and `req_cpl`>0.
- R9: `req_ready` = !`rsp_valid` | `rsp_ready`. The result of a request accepted on edge N is presented from edge N, and it is held unchanged while `rsp_valid`=1 and `rsp_ready`=0.
- R10: `rsp_fault` is registered together with `rsp_lin`. On a fault, `rsp_lin` still carries the computed address.
- R11: Segment codes 6 and 7 always fault. Their base counts as 0.
- R12: The access type `req_write` does not change `rsp_lin` or `rsp_fault`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Segment register write strobe |
| cfg_idx | input | 3 | Segment code to write |
| cfg_base | input | 64 | Base value to store |
| cfg_limit | input | 32 | Limit value to store |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with valid |
| req_seg | input | 3 | Segment code of the access |
| req_ea | input | 64 | Effective address |
| req_size | input | 4 | Access size in bytes (0 treated as 1) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_cpl | input | 2 | Current privilege level |
| req_mode64 | input | 1 | 1 = wide (64-bit) mode |
| req_limchk_en | input | 1 | Wide-mode limit-check enable |
| rsp_valid | output | 1 | Result valid |
| rsp_ready | input | 1 | Consumer can take the result |
| rsp_lin | output | 64 | Linear address |
| rsp_fault | output | 1 | Limit or segment-code fault; when high, the address is not usable |

## Verification
The checker watches the handshake on every cycle: the ready equation, and a held result that must stay stable under back-pressure. For each accepted request it also checks a few mode rules one cycle later. Wide-mode codes 0 to 3 must pass the address through unchanged. Codes 0 and 5 in wide mode, and any wide-mode access with the enable low, must never fault. A 32-bit-mode result must have a zero upper half.

The bench alone can show the following. Limit comparisons at the exact boundary give the right answer, including sums that would overflow. Bases add correctly, and a configuration write takes effect on the next edge. The access-type bit changes nothing.

// File: rtl/seg_pkg.sv
package seg_pkg;
  localparam int SEG_IDX_W = 3;

  typedef enum logic [SEG_IDX_W-1:0] {
    SEG_CODE = 3'd0,
    SEG_DATA = 3'd1,
    SEG_EXTR = 3'd2,
    SEG_STAK = 3'd3,
    SEG_AUXF = 3'd4,
    SEG_AUXG = 3'd5,
    SEG_BAD6 = 3'd6,
    SEG_BAD7 = 3'd7
  } seg_code_e;

  function automatic logic seg_is_valid(input logic [SEG_IDX_W-1:0] s);
    return s <= SEG_AUXG;
  endfunction

  function automatic logic seg_keeps_base_wide(input logic [SEG_IDX_W-1:0] s);
    return (s == SEG_AUXF) || (s == SEG_AUXG);
  endfunction

  function automatic logic seg_checked_wide(input logic [SEG_IDX_W-1:0] s);
    return (s == SEG_DATA) || (s == SEG_EXTR) || (s == SEG_STAK) || (s == SEG_AUXF);
  endfunction
endpackage

// File: rtl/seg_regfile.sv
module seg_regfile
  import seg_pkg::*;
#(
  parameter int NSEG  = 6,
  parameter int AW    = 64,
  parameter int LIM_W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [SEG_IDX_W-1:0] wr_idx,
  input  logic [AW-1:0]        wr_base,
  input  logic [LIM_W-1:0]     wr_limit,
  input  logic [SEG_IDX_W-1:0] rd_idx,
  output logic [AW-1:0]        rd_base,
  output logic [LIM_W-1:0]     rd_limit
);
  logic [AW-1:0]    base_q  [NSEG];
  logic [LIM_W-1:0] limit_q [NSEG];

  for (genvar g = 0; g < NSEG; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        base_q[g]  <= '0;
        limit_q[g] <= '1;
      end else if (wr_en && (int'(wr_idx) == g)) begin
        base_q[g]  <= wr_base;
        limit_q[g] <= wr_limit;
      end
    end
  end

  always_comb begin
    rd_base  = '0;
    rd_limit = '0;
    for (int i = 0; i < NSEG; i++) begin
      if (int'(rd_idx) == i) begin
        rd_base  = base_q[i];
        rd_limit = limit_q[i];
      end
    end
  end
endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
  import seg_pkg::*;
#(
  parameter int AW   = 64,
  parameter int LAW  = 32
) (
  input  logic [SEG_IDX_W-1:0] seg,
  input  logic                 mode64,
  input  logic [AW-1:0]        ea,
  input  logic [AW-1:0]        base,
  output logic [AW-1:0]        lin
);
  logic [AW-1:0]  wide_base;
  logic [LAW-1:0] narrow_sum;

  always_comb begin
    wide_base  = (seg_keeps_base_wide(seg)) ? base : '0;
    narrow_sum = ea[LAW-1:0] + base[LAW-1:0];
    if (mode64) lin = ea + wide_base;
    else        lin = {{(AW-LAW){1'b0}}, narrow_sum};
  end
endmodule

// File: rtl/seg_limit_check.sv
module seg_limit_check
  import seg_pkg::*;
#(
  parameter int AW    = 64,
  parameter int LAW   = 32,
  parameter int LIM_W = 32,
  parameter int SZ_W  = 4
) (
  input  logic [SEG_IDX_W-1:0] seg,
  input  logic                 mode64,
  input  logic                 lim_en,
  input  logic [1:0]           cpl,
  input  logic [AW-1:0]        ea,
  input  logic [SZ_W-1:0]      size,
  input  logic [LIM_W-1:0]     limit,
  output logic                 fault
);
  localparam int EW = AW + 1;

  logic [SZ_W-1:0] sz_m1;
  logic [EW-1:0]   ofs_ext;
  logic [EW-1:0]   last_byte;
  logic [EW-1:0]   lim_ext;
  logic            check_on;

  always_comb begin
    sz_m1     = (size == '0) ? '0 : size - 1'b1;
    ofs_ext   = mode64 ? {1'b0, ea} : {{(EW-LAW){1'b0}}, ea[LAW-1:0]};
    last_byte = ofs_ext + {{(EW-SZ_W){1'b0}}, sz_m1};
    lim_ext   = {{(EW-LIM_W){1'b0}}, limit};
    if (mode64) check_on = lim_en && (cpl != 2'd0) && seg_checked_wide(seg);
    else        check_on = 1'b1;
    fault = !seg_is_valid(seg) || (check_on && (last_byte > lim_ext));
  end
endmodule

// File: rtl/seg_out_stage.sv
module seg_out_stage #(
  parameter int AW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [AW-1:0] in_lin,
  input  logic          in_fault,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [AW-1:0] out_lin,
  output logic          out_fault
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_lin   <= '0;
      out_fault <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_lin   <= in_lin;
        out_fault <= in_fault;
      end
    end
  end
endmodule

// File: rtl/seg_addr_unit.sv
module seg_addr_unit
  import seg_pkg::*;
#(
  parameter int AW    = 64,
  parameter int LAW   = 32,
  parameter int LIM_W = 32,
  parameter int SZ_W  = 4,
  parameter int NSEG  = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [SEG_IDX_W-1:0] cfg_idx,
  input  logic [AW-1:0]        cfg_base,
  input  logic [LIM_W-1:0]     cfg_limit,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [SEG_IDX_W-1:0] req_seg,
  input  logic [AW-1:0]        req_ea,
  input  logic [SZ_W-1:0]      req_size,
  input  logic                 req_write,
  input  logic [1:0]           req_cpl,
  input  logic                 req_mode64,
  input  logic                 req_limchk_en,
  output logic                 rsp_valid,
  input  logic                 rsp_ready,
  output logic [AW-1:0]        rsp_lin,
  output logic                 rsp_fault
);
  logic [AW-1:0]    sel_base;
  logic [LIM_W-1:0] sel_limit;
  logic [AW-1:0]    lin_d;
  logic             fault_d;
  logic             unused_write;

  assign unused_write = req_write;

  seg_regfile #(.NSEG(NSEG), .AW(AW), .LIM_W(LIM_W)) u_rf (
    .clk(clk), .rst_n(rst_n),
    .wr_en(cfg_we), .wr_idx(cfg_idx), .wr_base(cfg_base), .wr_limit(cfg_limit),
    .rd_idx(req_seg), .rd_base(sel_base), .rd_limit(sel_limit)
  );

  seg_addr_gen #(.AW(AW), .LAW(LAW)) u_gen (
    .seg(req_seg), .mode64(req_mode64), .ea(req_ea), .base(sel_base), .lin(lin_d)
  );

  seg_limit_check #(.AW(AW), .LAW(LAW), .LIM_W(LIM_W), .SZ_W(SZ_W)) u_lim (
    .seg(req_seg), .mode64(req_mode64), .lim_en(req_limchk_en), .cpl(req_cpl),
    .ea(req_ea), .size(req_size), .limit(sel_limit), .fault(fault_d)
  );

  seg_out_stage #(.AW(AW)) u_out (
    .clk(clk), .rst_n(rst_n),
    .in_valid(req_valid), .in_ready(req_ready), .in_lin(lin_d), .in_fault(fault_d),
    .out_valid(rsp_valid), .out_ready(rsp_ready), .out_lin(rsp_lin), .out_fault(rsp_fault)
  );
endmodule

// File: rtl/seg_addr_unit_chk.sv
module seg_addr_unit_chk #(
  parameter int AW = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic [2:0]    req_seg,
  input logic [AW-1:0] req_ea,
  input logic          req_mode64,
  input logic          req_limchk_en,
  input logic          rsp_valid,
  input logic          rsp_ready,
  input logic [AW-1:0] rsp_lin,
  input logic          rsp_fault
);
  logic take;
  assign take = req_valid && req_ready;

  // R9
  ready_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready == (!rsp_valid || rsp_ready));

  // R9
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_lin) && $stable(rsp_fault)));

  // R9
  accept_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> rsp_valid);

  // R3
  flat_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && req_mode64 && (req_seg <= 3'd3)) |=> (rsp_lin == $past(req_ea)));

  // R8
  never_checked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && req_mode64 && ((req_seg == 3'd0) || (req_seg == 3'd5))) |=> !rsp_fault);

  // R7
  enable_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && req_mode64 && !req_limchk_en && (req_seg <= 3'd5)) |=> !rsp_fault);

  // R5
  narrow_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !req_mode64) |=> (rsp_lin[AW-1:32] == '0));
endmodule

bind seg_addr_unit seg_addr_unit_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_seg(req_seg), .req_ea(req_ea), .req_mode64(req_mode64),
  .req_limchk_en(req_limchk_en), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
  .rsp_lin(rsp_lin), .rsp_fault(rsp_fault)
);

// File: tb/sim_seg_addr_unit.sv
`timescale 1ns/1ps
module sim_seg_addr_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_idx = '0;
  logic [63:0] cfg_base = '0;
  logic [31:0] cfg_limit = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [2:0]  req_seg = '0;
  logic [63:0] req_ea = '0;
  logic [3:0]  req_size = 4'd1;
  logic        req_write = 1'b0;
  logic [1:0]  req_cpl = '0;
  logic        req_mode64 = 1'b0;
  logic        req_limchk_en = 1'b0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [63:0] rsp_lin;
  logic        rsp_fault;

  int checks = 0;
  int failures = 0;
  logic [63:0] m_base [6];
  logic [31:0] m_lim  [6];

  always #10 clk = ~clk;

  seg_addr_unit u0 (.*);

  initial begin
    #4_000_000;
    failures++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [64:0] model(input logic [2:0] s, input logic [63:0] ea,
      input logic [3:0] sz, input logic [1:0] cpl, input logic m64, input logic en);
    logic [63:0] b, lin;
    logic [31:0] l;
    logic [64:0] last;
    logic [3:0]  sm1;
    logic        f;
    b = (s <= 3'd5) ? m_base[s] : 64'd0;
    l = (s <= 3'd5) ? m_lim[s] : 32'd0;
    sm1 = (sz == 0) ? 4'd0 : sz - 4'd1;
    if (m64) begin
      lin  = ea + ((s == 3'd4 || s == 3'd5) ? b : 64'd0);
      last = {1'b0, ea} + 65'(sm1);
      f = en && cpl != 0 && (s >= 3'd1 && s <= 3'd4) && (last > 65'(l));
    end else begin
      lin  = {32'd0, ea[31:0] + b[31:0]};
      last = 65'(ea[31:0]) + 65'(sm1);
      f = last > 65'(l);
    end
    if (s > 3'd5) f = 1'b1;
    return {f, lin};
  endfunction

  task automatic cfg(input logic [2:0] i, input logic [63:0] b, input logic [31:0] l);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = i; cfg_base = b; cfg_limit = l;
    @(negedge clk);
    cfg_we = 1'b0;
    if (i <= 3'd5) begin m_base[i] = b; m_lim[i] = l; end
  endtask

  task automatic access(input string req, input logic [2:0] s, input logic [63:0] ea,
      input logic [3:0] sz, input logic [1:0] cpl, input logic m64, input logic en,
      input logic wr);
    logic [64:0] e;
    e = model(s, ea, sz, cpl, m64, en);
    @(negedge clk);
    req_valid = 1'b1; req_seg = s; req_ea = ea; req_size = sz;
    req_cpl = cpl; req_mode64 = m64; req_limchk_en = en; req_write = wr;
    @(negedge clk);
    req_valid = 1'b0;
    chk({req, " valid"}, 64'(rsp_valid), 64'd1);
    chk({req, " lin"}, rsp_lin, e[63:0]);
    chk({req, " fault"}, 64'(rsp_fault), 64'(e[64]));
  endtask

  initial begin
    logic [64:0] ea_exp, eb_exp;
    void'($urandom(32'd2718));
    for (int i = 0; i < 6; i++) begin m_base[i] = '0; m_lim[i] = '1; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 rsp_valid", 64'(rsp_valid), 64'd0);
    chk("R1 req_ready", 64'(req_ready), 64'd1);
    access("R1 reset base/limit", 3'd1, 64'hFFFF_FFFC, 4'd4, 2'd0, 1'b0, 1'b0, 1'b0);

    // R2 config effect next cycle
    cfg(3'd1, 64'h0000_0000_1000_0000, 32'h0000_0FFF);
    access("R2 new base", 3'd1, 64'h20, 4'd4, 2'd3, 1'b0, 1'b0, 1'b0);
    // R6 boundary exact fit / one past / overflow
    access("R6 fits at limit", 3'd1, 64'hFFC, 4'd4, 2'd3, 1'b0, 1'b0, 1'b0);
    access("R6 one past limit", 3'd1, 64'hFFD, 4'd4, 2'd3, 1'b0, 1'b0, 1'b0);
    cfg(3'd3, 64'h0, 32'hFFFF_FFFE);
    access("R6 no wrap sum", 3'd3, 64'hFFFF_FFFF, 4'd8, 2'd0, 1'b0, 1'b0, 1'b0);
    access("R6 size zero as one", 3'd1, 64'hFFF, 4'd0, 2'd0, 1'b0, 1'b0, 1'b0);
    // R5 32-bit wrap
    cfg(3'd2, 64'hABCD_0000_F000_0000, 32'hFFFF_FFFF);
    access("R5 narrow wrap", 3'd2, 64'h1234_5678_2000_0010, 4'd1, 2'd0, 1'b0, 1'b0, 1'b0);
    // R3 wide ignores base
    access("R3 wide data flat", 3'd1, 64'h8000_0000_0000_0040, 4'd8, 2'd0, 1'b1, 1'b0, 1'b0);
    cfg(3'd0, 64'h55, 32'h10);
    access("R3 wide code flat", 3'd0, 64'h7777_0000, 4'd2, 2'd3, 1'b1, 1'b1, 1'b0);
    // R4 wide aux keep base
    cfg(3'd4, 64'hFFFF_FFFF_FFFF_FF00, 32'h100);
    cfg(3'd5, 64'h0000_7000_0000_0000, 32'h0);
    access("R4 aux-F base wrap", 3'd4, 64'h200, 4'd1, 2'd0, 1'b1, 1'b0, 1'b0);
    access("R4 aux-G base", 3'd5, 64'h1234, 4'd8, 2'd3, 1'b1, 1'b1, 1'b0);
    // R7 gating
    access("R7 enabled cpl3 data", 3'd1, 64'h1000, 4'd1, 2'd3, 1'b1, 1'b1, 1'b0);
    access("R7 cpl0 no check", 3'd1, 64'h1000, 4'd1, 2'd0, 1'b1, 1'b1, 1'b0);
    access("R7 enable off", 3'd4, 64'h1000, 4'd1, 2'd2, 1'b1, 1'b0, 1'b0);
    access("R7 aux-F checked", 3'd4, 64'h0FF, 4'd2, 2'd1, 1'b1, 1'b1, 1'b0);
    access("R7 64-bit no wrap", 3'd3, 64'hFFFF_FFFF_FFFF_FFFF, 4'd2, 2'd1, 1'b1, 1'b1, 1'b0);
    // R8
    access("R8 aux-G unchecked", 3'd5, 64'hFFFF_0000, 4'd8, 2'd3, 1'b1, 1'b1, 1'b0);
    access("R8 code unchecked", 3'd0, 64'hFFFF_0000, 4'd8, 2'd3, 1'b1, 1'b1, 1'b0);
    // R10 fault still carries address
    access("R10 fault keeps lin", 3'd1, 64'h5000, 4'd1, 2'd0, 1'b0, 1'b0, 1'b0);
    // R11
    access("R11 code 6", 3'd6, 64'h42, 4'd1, 2'd0, 1'b1, 1'b0, 1'b0);
    access("R11 code 7", 3'd7, 64'h42, 4'd1, 2'd0, 1'b0, 1'b0, 1'b0);
    // R12 write vs read same result
    access("R12 write narrow", 3'd1, 64'hFFD, 4'd4, 2'd3, 1'b0, 1'b0, 1'b1);
    access("R12 write wide", 3'd2, 64'h99, 4'd4, 2'd3, 1'b1, 1'b1, 1'b1);

    // R9 back-pressure
    ea_exp = model(3'd4, 64'h10, 4'd1, 2'd0, 1'b1, 1'b0);
    eb_exp = model(3'd1, 64'h30, 4'd1, 2'd0, 1'b0, 1'b0);
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_seg = 3'd4; req_ea = 64'h10; req_size = 4'd1;
    req_cpl = 2'd0; req_mode64 = 1'b1; req_limchk_en = 1'b0; req_write = 1'b0;
    @(negedge clk);
    req_seg = 3'd1; req_ea = 64'h30; req_mode64 = 1'b0;
    chk("R9 ready low under stall", 64'(req_ready), 64'd0);
    repeat (3) @(negedge clk);
    chk("R9 held lin", rsp_lin, ea_exp[63:0]);
    chk("R9 held valid", 64'(rsp_valid), 64'd1);
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R9 second result lin", rsp_lin, eb_exp[63:0]);
    chk("R9 second result fault", 64'(rsp_fault), 64'(eb_exp[64]));
    @(negedge clk);
    chk("R9 drains", 64'(rsp_valid), 64'd0);

    // Random mix across R3-R8, R11
    for (int n = 0; n < 400; n++) begin
      logic [2:0]  s;
      logic [63:0] ea;
      logic [3:0]  sz;
      if (n % 40 == 0)
        cfg(3'($urandom % 6), {$urandom, $urandom}, $urandom % 32'h2_0000);
      s  = 3'($urandom % 8);
      sz = 4'($urandom % 9);
      if ($urandom % 2 == 0 && s <= 3'd5)
        ea = 64'(m_lim[s]) - 64'($urandom % 8) + 64'($urandom % 4);
      else
        ea = {$urandom, $urandom};
      access("R7 random mix", s, ea, sz, 2'($urandom % 4), 1'($urandom % 2),
             1'($urandom % 2), 1'($urandom % 2));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule